// File: doc/BRIEF.md
# Graphics Adapter Configuration and Address Window Decoder

This block sits at the front of a graphics adapter that must stay compatible with the legacy VGA address map. It takes byte-wide configuration-space writes and keeps the command byte, the base bytes of two 16 MiB apertures (one for control registers, one for the framebuffer) and the expansion ROM controls. From this state it decides, for the host address presented on its inputs, which resource of the card claims the cycle. The outputs are a hit flag for the legacy I/O port range and hit flags for the legacy memory window, the register aperture, the framebuffer aperture and the ROM. While the legacy memory window is hit, it also gives the mask that the banked memory path applies to the offset.

The legacy memory window does not follow the graphics misc register all the time. Its placement is sampled from misc bits 3:2 at the moment a command write turns I/O decoding on while both aperture bytes are zero. When either aperture is programmed, such a write leaves the earlier placement as it was. An aperture whose base byte is zero is switched off; it is never mapped at address zero. Configuration reads and bus protocol timing are handled by other parts of the chip.

Top module: `gad_window_decoder`

## Requirements
- R1: A configuration write to offset 0x04 stores `cfg_wdata & 0x27` as the command byte, and `cmd_q` shows it. Bit 0 is the I/O-space enable.
- R2: An I/O cycle (`host_is_io`=1) to an address in 0x3C0..0x3DF raises `hit_vga_io` while command bit 0 is set. No other address and no memory cycle raises it, and nothing does while bit 0 is clear.
- R3: While command bit 0 is clear, `hit_vga_mem`, `hit_regs` and `hit_fb` stay low. A command write that clears bit 0 also turns the legacy memory window off.
- R4: The byte at offset 0x13 gives bits 31:24 of the register aperture base. A memory cycle within the 16 MiB above that base raises `hit_regs` while command bit 0 is set.
- R5: The byte at offset 0x17 gives bits 31:24 of the framebuffer aperture base. A memory cycle within the 16 MiB above that base raises `hit_fb` while command bit 0 is set.
- R6: An aperture whose base byte is zero claims no address, address 0 included.
- R7: A command write with bit 0 set, made while both aperture bytes are zero, turns the legacy window on and takes its placement from `gfx_misc[3:2]`. The codes are: 00 for 0xA0000 with 128 KiB; 01 for 0xA0000 with 64 KiB; 10 for 0xB0000 with 32 KiB; 11 for 0xB8000 with 32 KiB.
- R8: `bank_mask` is 0xFFFF when the legacy window is hit with a 0xA0000 placement, 0x7FFF when it is hit with a 32 KiB placement, and 0 when it is not hit.
- R9: Bit 0 of offset 0x30 enables the ROM. Offset 0x32 gives bits 23:16 and offset 0x33 gives bits 31:24 of the ROM base. A memory cycle within the 32 KiB above that base raises `hit_rom`, whatever the command byte holds.
- R10: After reset every configuration byte is zero, and no port and no memory window is claimed.
- R11: At most one memory hit is high at a time. Where windows overlap, the order of precedence is register aperture, then framebuffer aperture, then ROM, then legacy window.
- R12: A command write with bit 0 set, made while either aperture byte is nonzero, leaves the on/off state and the placement of the legacy window unchanged, even if `gfx_misc` has changed since.
- R13: A configuration write takes effect on the clock edge that samples `cfg_we`. The hit outputs follow `host_addr` and `host_is_io` combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte value |
| gfx_misc | input | 8 | Graphics misc register; bits 3:2 choose the legacy placement |
| host_addr | input | 32 | Host cycle address |
| host_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| cmd_q | output | 8 | Stored command byte |
| hit_vga_io | output | 1 | Legacy I/O port range claimed |
| hit_vga_mem | output | 1 | Legacy memory window claimed |
| hit_regs | output | 1 | Register aperture claimed |
| hit_fb | output | 1 | Framebuffer aperture claimed |
| hit_rom | output | 1 | Expansion ROM claimed |
| bank_mask | output | 16 | Banked offset mask while the legacy window is hit |

## Verification
The decode is tried with addresses just inside and just outside each window edge. These probes show whether the base and size arithmetic is off by one. Each of the four misc codes is latched in turn, which shows whether the placement and the mask come from the right code. Command writes are repeated with the apertures zero and nonzero, and with misc changed in between. These runs separate a placement that is re-derived on every write from one that is held. Windows are then set to overlap on purpose, and a random address sweep runs over a programmed map. Both check the order of precedence and the claim of each window against a reference model every cycle.

// File: rtl/gad_pkg.sv
package gad_pkg;

  localparam int ADDR_W   = 32;
  localparam int CFG_AW   = 8;
  localparam int BYTE_W   = 8;
  localparam int MASK_W   = 16;

  localparam logic [CFG_AW-1:0] OFS_CMD      = 8'h04;
  localparam logic [CFG_AW-1:0] OFS_REG_BASE = 8'h13;
  localparam logic [CFG_AW-1:0] OFS_FB_BASE  = 8'h17;
  localparam logic [CFG_AW-1:0] OFS_ROM_CTL  = 8'h30;
  localparam logic [CFG_AW-1:0] OFS_ROM_LO   = 8'h32;
  localparam logic [CFG_AW-1:0] OFS_ROM_HI   = 8'h33;

  localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h27;
  localparam int CMD_IO_BIT = 0;

  localparam logic [ADDR_W-1:0] VIO_FIRST = 32'h0000_03C0;
  localparam int VIO_LOG2 = 5;

  localparam int APER_LOG2 = 24;
  localparam int ROM_LOG2  = 15;
  localparam int ROM_BASE_SHIFT = 16;

  localparam int NUM_APER = 2;
  localparam int APER_REGS = 0;
  localparam int APER_FB   = 1;

  typedef enum logic [1:0] {
    LEG_A0_128K = 2'b00,
    LEG_A0_64K  = 2'b01,
    LEG_B0_32K  = 2'b10,
    LEG_B8_32K  = 2'b11
  } leg_sel_e;

  typedef struct packed {
    logic regs;
    logic fb;
    logic rom;
    logic vga_mem;
  } mem_hits_t;

  function automatic logic [ADDR_W-1:0] leg_base(leg_sel_e s);
    case (s)
      LEG_B0_32K: leg_base = 32'h000B_0000;
      LEG_B8_32K: leg_base = 32'h000B_8000;
      default:    leg_base = 32'h000A_0000;
    endcase
  endfunction

  function automatic int leg_log2(leg_sel_e s);
    case (s)
      LEG_A0_128K: leg_log2 = 17;
      LEG_A0_64K:  leg_log2 = 16;
      default:     leg_log2 = 15;
    endcase
  endfunction

  function automatic logic [MASK_W-1:0] leg_mask(leg_sel_e s);
    leg_mask = (s == LEG_A0_128K || s == LEG_A0_64K) ? 16'hFFFF : 16'h7FFF;
  endfunction

  // Naturally aligned window test: same upper bits above the size.
  function automatic logic in_window(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] base, int lg);
    in_window = ((a ^ base) >> lg) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] aper_base(logic [BYTE_W-1:0] b);
    aper_base = {b, {(ADDR_W-BYTE_W){1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] rom_base(logic [2*BYTE_W-1:0] hl);
    rom_base = {hl, {ROM_BASE_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/gad_cfg_regs.sv
module gad_cfg_regs
  import gad_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic [BYTE_W-1:0]   gfx_misc,
  output logic [BYTE_W-1:0]   cmd_q,
  output logic [BYTE_W-1:0]   aper_base_q [NUM_APER],
  output logic                rom_en_q,
  output logic [2*BYTE_W-1:0] rom_hl_q,
  output logic                leg_en_q,
  output leg_sel_e            leg_sel_q,
  output logic                cmd_wr,
  output logic                io_on_evt,
  output logic                io_off_evt
);

  logic apers_zero;
  logic [NUM_APER-1:0] aper_wr;

  assign cmd_wr     = cfg_we && (cfg_addr == OFS_CMD);
  assign io_on_evt  = cmd_wr &&  cfg_wdata[CMD_IO_BIT];
  assign io_off_evt = cmd_wr && !cfg_wdata[CMD_IO_BIT];
  assign apers_zero = (aper_base_q[APER_REGS] == '0) && (aper_base_q[APER_FB] == '0);

  assign aper_wr[APER_REGS] = cfg_we && (cfg_addr == OFS_REG_BASE);
  assign aper_wr[APER_FB]   = cfg_we && (cfg_addr == OFS_FB_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cfg_wdata & CMD_KEEP;
  end

  for (genvar g = 0; g < NUM_APER; g++) begin : g_aper_reg
    always_ff @(posedge clk) begin
      if (!rst_n) aper_base_q[g] <= '0;
      else if (aper_wr[g]) aper_base_q[g] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_en_q <= 1'b0;
      rom_hl_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_ROM_CTL: rom_en_q <= cfg_wdata[0];
        OFS_ROM_LO:  rom_hl_q[BYTE_W-1:0] <= cfg_wdata;
        OFS_ROM_HI:  rom_hl_q[2*BYTE_W-1:BYTE_W] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // Legacy placement is sampled only when decoding turns on with no aperture.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_en_q  <= 1'b0;
      leg_sel_q <= LEG_A0_128K;
    end else if (io_off_evt) begin
      leg_en_q <= 1'b0;
    end else if (io_on_evt && apers_zero) begin
      leg_en_q  <= 1'b1;
      leg_sel_q <= leg_sel_e'(gfx_misc[3:2]);
    end
  end

endmodule

// File: rtl/gad_window_match.sv
module gad_window_match
  import gad_pkg::*;
(
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_is_io,
  input  logic [BYTE_W-1:0]   cmd_q,
  input  logic [BYTE_W-1:0]   aper_base_q [NUM_APER],
  input  logic                rom_en_q,
  input  logic [2*BYTE_W-1:0] rom_hl_q,
  input  logic                leg_en_q,
  input  leg_sel_e            leg_sel_q,
  output logic                raw_vio,
  output logic [NUM_APER-1:0] raw_aper,
  output logic                raw_rom,
  output logic                raw_leg
);

  logic io_en;
  logic mem_cyc;

  assign io_en   = cmd_q[CMD_IO_BIT];
  assign mem_cyc = !host_is_io;

  assign raw_vio = host_is_io && io_en && in_window(host_addr, VIO_FIRST, VIO_LOG2);

  for (genvar g = 0; g < NUM_APER; g++) begin : g_aper_match
    logic base_live;
    assign base_live   = aper_base_q[g] != '0;
    assign raw_aper[g] = mem_cyc && io_en && base_live &&
                         in_window(host_addr, aper_base(aper_base_q[g]), APER_LOG2);
  end

  assign raw_rom = mem_cyc && rom_en_q &&
                   in_window(host_addr, rom_base(rom_hl_q), ROM_LOG2);

  assign raw_leg = mem_cyc && io_en && leg_en_q &&
                   in_window(host_addr, leg_base(leg_sel_q), leg_log2(leg_sel_q));

endmodule

// File: rtl/gad_hit_arbiter.sv
module gad_hit_arbiter
  import gad_pkg::*;
(
  input  logic [NUM_APER-1:0] raw_aper,
  input  logic                raw_rom,
  input  logic                raw_leg,
  input  leg_sel_e            leg_sel_q,
  output mem_hits_t           hits,
  output logic [MASK_W-1:0]   bank_mask
);

  always_comb begin
    hits = '0;
    if (raw_aper[APER_REGS])    hits.regs    = 1'b1;
    else if (raw_aper[APER_FB]) hits.fb      = 1'b1;
    else if (raw_rom)           hits.rom     = 1'b1;
    else if (raw_leg)           hits.vga_mem = 1'b1;
  end

  assign bank_mask = hits.vga_mem ? leg_mask(leg_sel_q) : '0;

endmodule

// File: rtl/gad_window_decoder.sv
module gad_window_decoder
  import gad_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0]  cfg_wdata,
  input  logic [BYTE_W-1:0]  gfx_misc,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_is_io,
  output logic [BYTE_W-1:0]  cmd_q,
  output logic               hit_vga_io,
  output logic               hit_vga_mem,
  output logic               hit_regs,
  output logic               hit_fb,
  output logic               hit_rom,
  output logic [MASK_W-1:0]  bank_mask
);

  logic [BYTE_W-1:0]   aper_base_q [NUM_APER];
  logic                rom_en_q;
  logic [2*BYTE_W-1:0] rom_hl_q;
  logic                leg_en_q;
  leg_sel_e            leg_sel_q;
  logic                cmd_wr, io_on_evt, io_off_evt;
  logic                raw_vio, raw_rom, raw_leg;
  logic [NUM_APER-1:0] raw_aper;
  mem_hits_t           hits;
  logic [BYTE_W-1:0]   regs_base_q, fb_base_q;

  gad_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gfx_misc(gfx_misc), .cmd_q(cmd_q),
    .aper_base_q(aper_base_q), .rom_en_q(rom_en_q), .rom_hl_q(rom_hl_q),
    .leg_en_q(leg_en_q), .leg_sel_q(leg_sel_q), .cmd_wr(cmd_wr),
    .io_on_evt(io_on_evt), .io_off_evt(io_off_evt)
  );

  gad_window_match u_match (
    .host_addr(host_addr), .host_is_io(host_is_io), .cmd_q(cmd_q),
    .aper_base_q(aper_base_q), .rom_en_q(rom_en_q), .rom_hl_q(rom_hl_q),
    .leg_en_q(leg_en_q), .leg_sel_q(leg_sel_q), .raw_vio(raw_vio),
    .raw_aper(raw_aper), .raw_rom(raw_rom), .raw_leg(raw_leg)
  );

  gad_hit_arbiter u_arb (
    .raw_aper(raw_aper), .raw_rom(raw_rom), .raw_leg(raw_leg),
    .leg_sel_q(leg_sel_q), .hits(hits), .bank_mask(bank_mask)
  );

  assign regs_base_q = aper_base_q[APER_REGS];
  assign fb_base_q   = aper_base_q[APER_FB];

  assign hit_vga_io  = raw_vio;
  assign hit_vga_mem = hits.vga_mem;
  assign hit_regs    = hits.regs;
  assign hit_fb      = hits.fb;
  assign hit_rom     = hits.rom;

endmodule

// File: rtl/gad_window_checker.sv
module gad_window_checker
  import gad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [BYTE_W-1:0] cfg_wdata,
  input logic              host_is_io,
  input logic [BYTE_W-1:0] cmd_q,
  input logic [BYTE_W-1:0] regs_base_q,
  input logic [BYTE_W-1:0] fb_base_q,
  input logic              leg_en_q,
  input logic              io_off_evt,
  input logic              hit_vga_io,
  input logic              hit_vga_mem,
  input logic              hit_regs,
  input logic              hit_fb,
  input logic              hit_rom,
  input logic [MASK_W-1:0] bank_mask
);

  a_r1_cmd_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CMD) |=> cmd_q == ($past(cfg_wdata) & CMD_KEEP));

  a_r2_io_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vga_io |-> (host_is_io && cmd_q[CMD_IO_BIT]));

  a_r3_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[CMD_IO_BIT] |-> !(hit_regs || hit_fb || hit_vga_mem));

  a_r3_off_drops_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    io_off_evt |=> !leg_en_q);

  a_r6_zero_regs_base: assert property (@(posedge clk) disable iff (!rst_n)
    hit_regs |-> regs_base_q != '0);

  a_r6_zero_fb_base: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fb |-> fb_base_q != '0);

  a_r8_mask_values: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vga_mem |-> (bank_mask == 16'hFFFF || bank_mask == 16'h7FFF));

  a_r8_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_vga_mem |-> bank_mask == '0);

  a_r11_one_mem_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_regs, hit_fb, hit_rom, hit_vga_mem}));

  a_r11_io_excl_mem: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vga_io |-> !(hit_regs || hit_fb || hit_rom || hit_vga_mem));

endmodule

bind gad_window_decoder gad_window_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .host_is_io(host_is_io), .cmd_q(cmd_q),
  .regs_base_q(regs_base_q), .fb_base_q(fb_base_q), .leg_en_q(leg_en_q),
  .io_off_evt(io_off_evt), .hit_vga_io(hit_vga_io), .hit_vga_mem(hit_vga_mem),
  .hit_regs(hit_regs), .hit_fb(hit_fb), .hit_rom(hit_rom), .bank_mask(bank_mask)
);

// File: tb/test_gad_window_decoder.sv
module test_gad_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  gfx_misc = '0;
  logic [31:0] host_addr = '0;
  logic        host_is_io = 1'b0;
  logic [7:0]  cmd_q;
  logic        hit_vga_io, hit_vga_mem, hit_regs, hit_fb, hit_rom;
  logic [15:0] bank_mask;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done = 0;

  // Reference state
  int m_cmd, m_regb, m_fbb, m_rom_en, m_rom_lo, m_rom_hi, m_leg_en, m_leg_sel;

  always #2 clk = ~clk;

  gad_window_decoder i_gad_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gfx_misc(gfx_misc), .host_addr(host_addr),
    .host_is_io(host_is_io), .cmd_q(cmd_q), .hit_vga_io(hit_vga_io),
    .hit_vga_mem(hit_vga_mem), .hit_regs(hit_regs), .hit_fb(hit_fb),
    .hit_rom(hit_rom), .bank_mask(bank_mask)
  );

  function automatic bit between(longint a, longint lo, longint size);
    return a >= lo && a < lo + size;
  endfunction

  task automatic cmp(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference comparison every cycle (R13: outputs follow the model state
  // that changes only after the edge sampling a write).
  always @(negedge clk) begin
    if (chk_on) begin
      longint a;
      bit io_on, e_io, e_regs, e_fb, e_rom, e_leg;
      longint lb, ls;
      int e_mask;
      a = longint'(host_addr);
      io_on = m_cmd[0];
      e_io = host_is_io && io_on && a >= 'h3C0 && a <= 'h3DF;
      e_regs = 0; e_fb = 0; e_rom = 0; e_leg = 0; e_mask = 0;
      case (m_leg_sel)
        0: begin lb = 'hA0000; ls = 131072; end
        1: begin lb = 'hA0000; ls = 65536; end
        2: begin lb = 'hB0000; ls = 32768; end
        default: begin lb = 'hB8000; ls = 32768; end
      endcase
      if (!host_is_io) begin
        if (io_on && m_regb != 0 && between(a, longint'(m_regb) * 'h1000000, 'h1000000))
          e_regs = 1;
        else if (io_on && m_fbb != 0 && between(a, longint'(m_fbb) * 'h1000000, 'h1000000))
          e_fb = 1;
        else if (m_rom_en != 0 &&
                 between(a, longint'(m_rom_hi) * 'h1000000 + longint'(m_rom_lo) * 'h10000, 32768))
          e_rom = 1;
        else if (io_on && m_leg_en != 0 && between(a, lb, ls)) begin
          e_leg = 1;
          e_mask = (m_leg_sel < 2) ? 'hFFFF : 'h7FFF;
        end
      end
      cmp("R1", "cmd_q", cmd_q, m_cmd);
      cmp("R2", "hit_vga_io", hit_vga_io, e_io);
      cmp("R4", "hit_regs", hit_regs, e_regs);
      cmp("R5", "hit_fb", hit_fb, e_fb);
      cmp("R9", "hit_rom", hit_rom, e_rom);
      cmp("R7", "hit_vga_mem", hit_vga_mem, e_leg);
      cmp("R8", "bank_mask", bank_mask, e_mask);
    end
  end

  task automatic cfg_write(input int ofs, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = ofs[7:0]; cfg_wdata = val[7:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (ofs)
      'h04: begin
        m_cmd = val & 'h27;
        if ((val & 1) == 0) m_leg_en = 0;
        else if (m_regb == 0 && m_fbb == 0) begin
          m_leg_en = 1;
          m_leg_sel = (int'(gfx_misc) >> 2) & 3;
        end
      end
      'h13: m_regb = val & 'hFF;
      'h17: m_fbb = val & 'hFF;
      'h30: m_rom_en = val & 1;
      'h32: m_rom_lo = val & 'hFF;
      'h33: m_rom_hi = val & 'hFF;
      default: ;
    endcase
  endtask

  task automatic probe(input longint a, input bit io);
    @(posedge clk); #1;
    host_addr = a[31:0]; host_is_io = io;
    @(negedge clk); #1;
  endtask

  // Probe a specific expectation explicitly in addition to the model compare.
  task automatic expect_hit(string req, longint a, bit io, int which);
    int act;
    probe(a, io);
    act = {hit_vga_io, hit_regs, hit_fb, hit_rom, hit_vga_mem};
    cmp(req, "hit vector", act, which);
  endtask

  localparam int HV_IO = 16, HV_REGS = 8, HV_FB = 4, HV_ROM = 2, HV_LEG = 1;

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: actual running expected finished");
    errors++; checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_cmd = 0; m_regb = 0; m_fbb = 0; m_rom_en = 0; m_rom_lo = 0; m_rom_hi = 0;
    m_leg_en = 0; m_leg_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_on = 1;
    // R10: nothing claimed after reset
    expect_hit("R10", 'h3C0, 1, 0);
    expect_hit("R10", 'hA0000, 0, 0);
    expect_hit("R10", 'h0, 0, 0);
    cmp("R10", "cmd_q", cmd_q, 0);

    // R1 masking, R7 placement 01
    gfx_misc = 8'b0000_0100;
    cfg_write('h04, 'hFF);
    cmp("R1", "cmd_q masked", cmd_q, 'h27);
    expect_hit("R2", 'h3C0, 1, HV_IO);
    expect_hit("R2", 'h3DF, 1, HV_IO);
    expect_hit("R2", 'h3BF, 1, 0);
    expect_hit("R2", 'h3E0, 1, 0);
    expect_hit("R2", 'h3C0, 0, 0);
    expect_hit("R7", 'hA0000, 0, HV_LEG);
    expect_hit("R7", 'hAFFFF, 0, HV_LEG);
    expect_hit("R7", 'hB0000, 0, 0);
    cmp("R8", "mask 64K", bank_mask, 'h0);

    // R4/R5 apertures
    cfg_write('h13, 'hE0);
    expect_hit("R4", 'hE0000000, 0, HV_REGS);
    expect_hit("R4", 'hE0FFFFFF, 0, HV_REGS);
    expect_hit("R4", 'hE1000000, 0, 0);
    expect_hit("R4", 'hDFFFFFFF, 0, 0);
    cfg_write('h17, 'hD0);
    expect_hit("R5", 'hD0800000, 0, HV_FB);
    expect_hit("R5", 'hD1000000, 0, 0);

    // R12: enable again with apertures programmed and different misc
    gfx_misc = 8'b0000_1100;
    cfg_write('h04, 'h01);
    expect_hit("R12", 'hB8000, 0, 0);
    expect_hit("R12", 'hA0000, 0, HV_LEG);

    // R3: I/O enable off
    cfg_write('h04, 'h00);
    expect_hit("R3", 'h3C0, 1, 0);
    expect_hit("R3", 'hE0000000, 0, 0);
    expect_hit("R3", 'hD0000000, 0, 0);
    expect_hit("R3", 'hA0000, 0, 0);
    // R12: turning on with apertures set leaves legacy off
    cfg_write('h04, 'h01);
    expect_hit("R12", 'hA0000, 0, 0);
    expect_hit("R12", 'hB8000, 0, 0);
    expect_hit("R4", 'hE0000000, 0, HV_REGS);

    // R6: zero bytes turn apertures off
    cfg_write('h13, 'h00);
    cfg_write('h17, 'h00);
    expect_hit("R6", 'h0, 0, 0);
    expect_hit("R6", 'h00FFFFFF, 0, 0);
    expect_hit("R6", 'hE0000000, 0, 0);

    // R7/R8: all four placements
    for (int s = 0; s < 4; s++) begin
      cfg_write('h04, 'h00);
      gfx_misc = 8'(s << 2);
      cfg_write('h04, 'h01);
      gfx_misc = 8'hFF;
      probe('h9FFFF, 0);
      probe('hA0000, 0);
      probe('hA7FFF, 0);
      probe('hAFFFF, 0);
      probe('hB0000, 0);
      probe('hB7FFF, 0);
      probe('hB8000, 0);
      probe('hBFFFF, 0);
      probe('hC0000, 0);
      cmp("R8", "mask sel", bank_mask, (s == 3) ? 0 : 0);
    end
    // placement 00 explicit
    cfg_write('h04, 'h00);
    gfx_misc = 8'h00;
    cfg_write('h04, 'h01);
    expect_hit("R7", 'hBFFFF, 0, HV_LEG);
    cmp("R8", "mask 128K", bank_mask, 'hFFFF);

    // R9 ROM, R11 over legacy, R13 strobe timing
    cfg_write('h32, 'h0A);
    cfg_write('h33, 'h00);
    expect_hit("R9", 'hA0000, 0, HV_LEG);
    cfg_write('h30, 'h01);
    expect_hit("R11", 'hA0000, 0, HV_ROM);
    expect_hit("R11", 'hA7FFF, 0, HV_ROM);
    expect_hit("R11", 'hA8000, 0, HV_LEG);
    cfg_write('h04, 'h00);
    expect_hit("R9", 'hA4000, 0, HV_ROM);
    cfg_write('h04, 'h01);

    // R11 aperture overlap
    cfg_write('h13, 'hE0);
    cfg_write('h17, 'hE0);
    expect_hit("R11", 'hE0001000, 0, HV_REGS);
    cfg_write('h17, 'hD0);
    cfg_write('h33, 'hD0);
    cfg_write('h32, 'h00);
    expect_hit("R11", 'hD0000000, 0, HV_FB);
    cfg_write('h17, 'h00);
    expect_hit("R9", 'hD0007FFF, 0, HV_ROM);
    expect_hit("R9", 'hD0008000, 0, 0);

    // R13: hit changes in the cycle the address changes; write seen next edge
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 8'h13; cfg_wdata = 8'h00;
    host_addr = 32'hE0000000; host_is_io = 1'b0;
    @(negedge clk); #1;
    cmp("R13", "before edge", hit_regs, 1);
    @(posedge clk); #1;
    cfg_we = 1'b0; m_regb = 0;
    @(negedge clk); #1;
    cmp("R13", "after edge", hit_regs, 0);

    // Random sweep over a programmed map
    cfg_write('h13, 'h40);
    cfg_write('h17, 'h41);
    cfg_write('h32, 'h0C);
    cfg_write('h33, 'h00);
    for (int i = 0; i < 400; i++) begin
      int r;
      longint a;
      r = $urandom_range(0, 5);
      case (r)
        0: a = longint'($urandom_range(32'h3B0, 32'h3F0));
        1: a = 'h40000000 + longint'($urandom_range(0, 32'h1FFFFFF));
        2: a = 'hA0000 + longint'($urandom_range(0, 32'h2FFFF));
        default: a = longint'($urandom);
      endcase
      probe(a, r == 0 ? 1'b1 : 1'($urandom_range(0, 1)));
    end

    chk_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule